// File: doc/BRIEF.md
# Dual-Mode 8/16-bit Timer

This block is a timer counter whose width is chosen by a mode input. In narrow mode a low count byte climbs until it equals a compare value, then restarts from zero. The compare value is not the programmable high-byte register itself. It is a private copy of it that is refreshed only when a match happens, so a new period written by software takes effect at the next period boundary. In wide mode the two bytes form one 16-bit counter that wraps from 0xFFFF to 0x0000 and runs without a limit.

The counter advances only on cycles where the single-cycle `tick` strobe is high. That strobe stands for the rising edge of whatever count source the surrounding logic has chosen. Software reaches the block through a byte-wide register bus: a select line picks the low or the high byte, and read and write strobes act on the selected byte. In wide mode the high byte goes through holding registers in both directions. A write to the high byte lands in a buffer that is loaded together with the next low-byte write. A read of the low byte captures the live high byte, so a later high-byte read returns a value coherent with it. A one-cycle event output marks every narrow-mode match and every wide-mode wrap.

Top module: `dual_timer`

## Requirements
- R1: `wide_mode` = 0 selects narrow (8-bit) operation and `wide_mode` = 1 selects wide (16-bit) operation. On any clock edge where `wide_mode` is 0, the high count byte is cleared and the started flag is dropped.
- R2: In narrow mode, a `tick` whose low count differs from the compare copy increments the low count by one, wrapping 0xFF to 0x00. A low-byte write (`bus_wr`=1, `bus_sel_hi`=0) loads the low count from `bus_wdata` at any time.
- R3: In narrow mode, a `tick` whose low count equals the compare copy clears the low count. The same edge copies the high-byte register into the compare copy, using the register value from before any high-byte write in that same cycle. The compare copy is zero after reset.
- R4: In wide mode, each counting `tick` adds one to the 16-bit value {high, low}, and 0xFFFF is followed by 0x0000.
- R5: A high-byte write (`bus_wr`=1, `bus_sel_hi`=1) stores `bus_wdata` in the high-byte register and nothing else. In wide mode, a permitted low-byte write loads high and low together as {high-byte register, `bus_wdata`}.
- R6: In wide mode, once a `tick` has been seen, low-byte writes are ignored and the count keeps running. This holds until reset, or until an edge with `wide_mode` = 0.
- R7: With `tick` low, no count changes except through a write. A permitted low-byte write in the same cycle as `tick` wins, and that tick does not count (no match, no wrap, no event).
- R8: `bus_rdata` is combinational. It returns the low count when `bus_sel_hi` = 0. When `bus_sel_hi` = 1 it returns the capture register in wide mode and the high-byte register in narrow mode. A read strobe on the low byte (`bus_rd`=1, `bus_sel_hi`=0) captures the high count byte as it was in that cycle.
- R9: `evt` is high for exactly the cycle after an edge on which a narrow match or a wide wrap occurred, and low otherwise.
- R10: A synchronous `rst` clears the counts, the high-byte register, the compare copy, the capture register, the started flag and `evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle count strobe (selected source rising edge) |
| wide_mode | input | 1 | 0 = narrow 8-bit, 1 = wide 16-bit |
| bus_sel_hi | input | 1 | Register select: 0 = low byte, 1 = high byte |
| bus_wr | input | 1 | Write strobe for the selected byte |
| bus_rd | input | 1 | Read strobe for the selected byte |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for the selected byte |
| evt | output | 1 | One-cycle match / wrap event |

## Verification
Two pairs of functions can fall on the same edge. The first is a low-byte read that captures the high count while a `tick` carries from 0x..FF into the high byte. The second is a narrow-mode compare-copy refresh while software writes a new period into the high-byte register. The bench uses its reference model to find the cycle where the low count sits at 0xFF, or equals the compare copy, and issues the read or write exactly there. It then judges the capture by the following high-byte read, and judges the refresh by the length of the next period as seen in the low byte and in `evt`.

// File: rtl/dt_pkg.sv
package dt_pkg;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } dt_mode_e;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } dt_sel_e;

  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic rd_lo;
  } dt_strobe_s;

endpackage

// File: rtl/dt_decode.sv
module dt_decode
  import dt_pkg::*;
(
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  dt_sel_e    sel,
  output dt_strobe_s strb
);

  always_comb begin
    strb.wr_lo = bus_wr & (sel == SEL_LO);
    strb.wr_hi = bus_wr & (sel == SEL_HI);
    strb.rd_lo = bus_rd & (sel == SEL_LO);
  end

  always_comb begin
    assert (!(strb.wr_lo && strb.wr_hi))
      else $error("both byte writes decoded at once (R5)");
  end

endmodule

// File: rtl/dt_hold.sv
module dt_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] live_hi,
  output logic [BYTE_W-1:0] hi_reg,
  output logic [BYTE_W-1:0] rd_buf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_reg <= '0;
      rd_buf <= '0;
    end else begin
      if (wr_hi) hi_reg <= wdata;
      if (rd_lo) rd_buf <= live_hi;
    end
  end

  // R8: a low-byte read freezes the live high byte of that cycle
  assert_read_capture_R8: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (rd_buf == $past(live_hi)));

  // R5: the high-byte register changes only on a high-byte write
  assert_hi_reg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(hi_reg));

endmodule

// File: rtl/dt_core.sv
module dt_core
  import dt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  dt_mode_e          mode,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] hi_reg,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              evt
);

  localparam int CNT_W = 2 * BYTE_W;

  // next narrow low count: restart on a compare hit, else add one
  function automatic logic [BYTE_W-1:0] f_next_narrow(input logic [BYTE_W-1:0] lo,
                                                      input logic             hit);
    return hit ? '0 : lo + BYTE_W'(1);
  endfunction

  // wide increment returning {carry_out, sum}
  function automatic logic [CNT_W:0] f_inc_wide(input logic [CNT_W-1:0] v);
    return {1'b0, v} + (CNT_W+1)'(1);
  endfunction

  logic [BYTE_W-1:0] cmp_buf;
  logic              started;
  logic              wide;
  logic              load_ok;
  logic              step;
  logic              lo_eq;
  logic [CNT_W:0]    inc_res;
  logic              match8;
  logic              wrap16;
  logic [BYTE_W-1:0] next_lo8;

  assign wide     = (mode == MODE_WIDE);
  assign load_ok  = wr_lo & (~wide | ~started);
  assign step     = tick & ~load_ok;
  assign lo_eq    = (cnt_lo == cmp_buf);
  assign inc_res  = f_inc_wide({cnt_hi, cnt_lo});
  assign match8   = ~wide & step & lo_eq;
  assign wrap16   = wide & step & inc_res[CNT_W];
  assign next_lo8 = f_next_narrow(cnt_lo, lo_eq);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo  <= '0;
      cnt_hi  <= '0;
      cmp_buf <= '0;
      started <= 1'b0;
      evt     <= 1'b0;
    end else begin
      evt <= match8 | wrap16;
      if (wide) begin
        started <= started | tick;
        if (load_ok) begin
          cnt_hi <= hi_reg;
          cnt_lo <= wdata;
        end else if (step) begin
          {cnt_hi, cnt_lo} <= inc_res[CNT_W-1:0];
        end
      end else begin
        started <= 1'b0;
        cnt_hi  <= '0;
        if (load_ok)    cnt_lo <= wdata;
        else if (step)  cnt_lo <= next_lo8;
        if (match8)     cmp_buf <= hi_reg;
      end
    end
  end

  // R2: a narrow tick that misses the compare copy adds one
  assert_narrow_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (!wide && step && !lo_eq) |=> (cnt_lo == $past(cnt_lo) + BYTE_W'(1)));

  // R3: a narrow match restarts the count and refreshes the compare copy
  assert_narrow_match_R3: assert property (@(posedge clk) disable iff (rst)
    match8 |=> (cnt_lo == '0 && cmp_buf == $past(hi_reg)));

  // R4: a wide wrap lands on zero
  assert_wide_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    wrap16 |=> (cnt_lo == '0 && cnt_hi == '0));

  // R6: once started, a low write without a tick leaves the count alone
  assert_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (wide && started && wr_lo && !tick) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R7: no tick and no write means no movement
  assert_idle_lo_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lo) |=> $stable(cnt_lo));
  assert_idle_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lo && wide) |=> $stable(cnt_hi));

  // R9: the event is seen only with the count at its restart point
  assert_evt_narrow_R9: assert property (@(posedge clk) disable iff (rst)
    (evt && !$past(wide)) |-> (cnt_lo == '0));
  assert_evt_wide_R9: assert property (@(posedge clk) disable iff (rst)
    (evt && $past(wide)) |-> (cnt_lo == '0 && cnt_hi == '0));

  // R1: narrow mode keeps the high count empty
  assert_narrow_hi_R1: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (cnt_hi == '0));

endmodule

// File: rtl/dt_rdmux.sv
module dt_rdmux
  import dt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  dt_mode_e          mode,
  input  dt_sel_e           sel,
  input  logic [BYTE_W-1:0] cnt_lo,
  input  logic [BYTE_W-1:0] hi_reg,
  input  logic [BYTE_W-1:0] rd_buf,
  output logic [BYTE_W-1:0] rdata
);

  always_comb begin
    unique case (sel)
      SEL_LO:  rdata = cnt_lo;
      SEL_HI:  rdata = (mode == MODE_WIDE) ? rd_buf : hi_reg;
      default: rdata = cnt_lo;
    endcase
  end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wide_mode,
  input  logic              bus_sel_hi,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              evt
);

  dt_mode_e          mode;
  dt_sel_e           sel;
  dt_strobe_s        strb;
  logic [BYTE_W-1:0] cnt_lo;
  logic [BYTE_W-1:0] cnt_hi;
  logic [BYTE_W-1:0] hi_reg;
  logic [BYTE_W-1:0] rd_buf;

  assign mode = dt_mode_e'(wide_mode);
  assign sel  = dt_sel_e'(bus_sel_hi);

  dt_decode u_decode (
    .bus_wr (bus_wr),
    .bus_rd (bus_rd),
    .sel    (sel),
    .strb   (strb)
  );

  dt_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_hi   (strb.wr_hi),
    .rd_lo   (strb.rd_lo),
    .wdata   (bus_wdata),
    .live_hi (cnt_hi),
    .hi_reg  (hi_reg),
    .rd_buf  (rd_buf)
  );

  dt_core #(.BYTE_W(BYTE_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .mode   (mode),
    .wr_lo  (strb.wr_lo),
    .wdata  (bus_wdata),
    .hi_reg (hi_reg),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .evt    (evt)
  );

  dt_rdmux #(.BYTE_W(BYTE_W)) u_rdmux (
    .mode   (mode),
    .sel    (sel),
    .cnt_lo (cnt_lo),
    .hi_reg (hi_reg),
    .rd_buf (rd_buf),
    .rdata  (bus_rdata)
  );

  // R10: reset leaves every stored value at zero
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!evt && cnt_lo == '0 && cnt_hi == '0 && hi_reg == '0 && rd_buf == '0));

endmodule

// File: tb/test_dual_timer.sv
`timescale 1ns/1ps
module test_dual_timer;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          wide_mode = 1'b0;
  logic          bus_sel_hi = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          evt;

  always #2.5 clk = ~clk;

  dual_timer #(.BYTE_W(BW)) i_dual_timer (
    .clk(clk), .rst(rst), .tick(tick), .wide_mode(wide_mode),
    .bus_sel_hi(bus_sel_hi), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int m_lo, m_hi, m_hreg, m_cmp, m_rb, m_evt;
  bit m_started;

  function automatic int exp_rd();
    if (!bus_sel_hi) return m_lo;
    return wide_mode ? m_rb : m_hreg;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int  o_lo, o_hi, v;
    bit  ld, st;
    if (rst) begin
      m_lo = 0; m_hi = 0; m_hreg = 0; m_cmp = 0; m_rb = 0; m_evt = 0; m_started = 0;
    end else begin
      o_lo = m_lo;
      o_hi = m_hi;
      ld = bus_wr && !bus_sel_hi && (!wide_mode || !m_started);
      st = tick && !ld;
      m_evt = 0;
      if (bus_rd && !bus_sel_hi) m_rb = o_hi;
      if (wide_mode) begin
        if (tick) m_started = 1;
        if (ld) begin
          m_lo = int'(bus_wdata);
          m_hi = m_hreg;
        end else if (st) begin
          v = (o_hi * 256 + o_lo + 1) % 65536;
          if (v == 0) m_evt = 1;
          m_hi = v / 256;
          m_lo = v % 256;
        end
      end else begin
        m_started = 0;
        m_hi = 0;
        if (ld) m_lo = int'(bus_wdata);
        else if (st) begin
          if (o_lo == m_cmp) begin
            m_lo = 0; m_cmp = m_hreg; m_evt = 1;
          end else begin
            m_lo = (o_lo + 1) % 256;
          end
        end
      end
      if (bus_wr && bus_sel_hi) m_hreg = int'(bus_wdata);
    end
  endtask

  // one bus cycle: drive, check read data, clock, check event
  task automatic cyc(input string tag, input bit t, input bit w, input bit r,
                     input bit s, input int wd);
    @(negedge clk);
    tick = t; bus_wr = w; bus_rd = r; bus_sel_hi = s; bus_wdata = BW'(wd);
    #1 check(tag, int'(bus_rdata), exp_rd());
    @(posedge clk);
    model_edge();
    #1 check({tag, " / R9 event"}, int'(evt), m_evt);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; tick = 0; bus_wr = 0; bus_rd = 0;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    cyc("R10 low after reset", 0, 0, 0, 0, 0);
    cyc("R10 high after reset", 0, 0, 0, 1, 0);
    check("R10 event after reset", int'(evt), 0);

    // R1 narrow mode, R3 period setup: first tick matches the zero compare copy
    wide_mode = 0;
    cyc("R5 write period", 0, 1, 0, 1, 3);
    cyc("R3 first match refresh", 1, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) begin
      cyc("R2 narrow count", 1, 0, 0, 0, 0);
      if (i % 4 == 1) cyc("R7 idle hold", 0, 0, 0, 0, 0);
    end

    // R3 collision: period write on the matching tick; old value is copied
    while (m_lo != m_cmp) cyc("R2 approach match", 1, 0, 0, 0, 0);
    cyc("R3 match with high write", 1, 1, 0, 1, 6);
    for (int i = 0; i < 12; i++) cyc("R3 period from old value", 1, 0, 0, 0, 0);
    cyc("R8 narrow high reads register", 0, 0, 1, 1, 0);

    // R7 low write beats tick; R2 load above compare wraps through 0xFF
    cyc("R7 write beats tick", 1, 1, 0, 0, 2);
    cyc("R2 load high value", 0, 1, 0, 0, 8'hFE);
    for (int i = 0; i < 6; i++) cyc("R2 wrap through FF", 1, 0, 0, 0, 0);

    // wide mode
    do_reset();
    wide_mode = 1;
    cyc("R5 high buffer write", 0, 1, 0, 1, 8'hFF);
    cyc("R8 high before capture", 0, 0, 1, 1, 0);
    cyc("R5 atomic load", 0, 1, 0, 0, 8'hFD);
    cyc("R8 capture low read", 0, 0, 1, 0, 0);
    cyc("R8 coherent high", 0, 0, 1, 1, 0);
    cyc("R4 wide count", 1, 0, 0, 0, 0);
    cyc("R4 wide count", 1, 0, 0, 0, 0);
    cyc("R8 read on carry tick", 1, 0, 1, 0, 0);
    cyc("R8 high from before carry", 0, 0, 1, 1, 0);
    cyc("R8 fresh capture", 0, 0, 1, 0, 0);
    cyc("R4 high after wrap", 0, 0, 1, 1, 0);
    cyc("R6 write after start ignored", 0, 1, 0, 0, 8'h55);
    cyc("R6 low unchanged", 0, 0, 0, 0, 0);
    cyc("R6 write with tick ignored", 1, 1, 0, 0, 8'h77);
    cyc("R6 count kept running", 0, 0, 0, 0, 0);

    // carry into the high byte with a coinciding low read
    cyc("R5 high buffer", 0, 1, 0, 1, 8'h12);
    wide_mode = 0;
    cyc("R1 leave wide", 0, 0, 0, 0, 0);
    wide_mode = 1;
    cyc("R5 reload after restart", 0, 1, 0, 0, 8'hFF);
    cyc("R8 read at carry", 1, 0, 1, 0, 0);
    cyc("R8 captured pre-carry high", 0, 0, 1, 1, 0);
    cyc("R8 recapture", 0, 0, 1, 0, 0);
    cyc("R4 carried high", 0, 0, 1, 1, 0);

    // R1 back to narrow mode
    wide_mode = 0;
    for (int i = 0; i < 8; i++) cyc("R1 narrow again", 1, 0, 1, i % 2, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 399) == 0) do_reset();
      if ($urandom_range(0, 149) == 0) wide_mode = ~wide_mode;
      cyc("R1 random mix",
          $urandom_range(0, 2) != 0,
          $urandom_range(0, 9) == 0,
          $urandom_range(0, 3) == 0,
          $urandom_range(0, 1) == 1,
          $urandom_range(0, 255));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule